// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a simple register bus and a behavioural array of one-time-programmable fuse words. Software selects a fuse word through an address field in a control register, then either senses the word into a result register or burns a 32-bit pattern into it. Each operation runs as a relax interval followed by a strobe interval. Both lengths are counted in clock cycles from a programmable timing register. A busy flag stays high for the whole operation.

Programming is guarded in three ways. A 16-bit unlock key must be present in the control register. The target bank must not be locked by a writable per-bank mask. The controller must be idle. A refused request sets a sticky error flag, which software clears through a clear alias of the control register. Burning can only turn fuse bits from 0 to 1, so the stored word accumulates the OR of every pattern programmed into it.

Top module: `fusebox_ctrl`

## Requirements
- R1: After reset the control register reads 0x00000000, the timing register reads 0x00061014 (read strobe 6, relax 1, program strobe 20), and the sense-data and bank-lock registers read 0.
- R2: Register offsets are 0 control, 1 control-set alias, 2 control-clear alias, 3 timing, 4 sense start, 5 program data, 6 sense data, 7 bank lock. All three control offsets read back {key[31:16], error[9], busy[8], address[6:0]}, with every other bit 0. A write to offset 0 loads the key and address fields. Offset 1 ORs the written bits into those fields. Offset 2 clears the written bits in those fields. The busy and error bits cannot be set by a write.
- R3: Writing 1 in bit 0 at offset 4 while idle starts a sense of the addressed word. Busy stays high for exactly (relax+1)+(read strobe+1) cycles, and offset 6 then holds that word. A write at offset 4 with bit 0 at 0 has no effect.
- R4: A write at offset 5 while idle, with key 0x3E77 and an unlocked bank, starts a program. Busy stays high for (relax+1)+(program strobe+1) cycles. At the end the stored word becomes its old value OR the written data, and the key field returns to 0.
- R5: A program request while idle with any key other than 0x3E77 sets the error flag, does not raise busy and leaves the array unchanged.
- R6: Bit b of the bank-lock register (offset 7) blocks programming of bank b. An attempt on a locked bank sets the error flag, leaves the key field and the array unchanged, and does not raise busy.
- R7: A sense or program request while busy sets the error flag and is otherwise ignored. The running operation completes unchanged.
- R8: The error flag stays set until bit 9 is written as 1 at offset 2. Writes at offset 0, or at offset 2 without bit 9, leave it set.
- R9: The timing register holds read strobe in bits 21:16, relax in bits 15:12 and program strobe in bits 11:0. Bits 31:22 read 0.
- R10: The 7-bit address selects bank address[6:3] and word address[2:0]. Each of the 128 words is stored independently, so programming one word leaves its neighbours at their own values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable (read data is combinational) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when bus_rd is low |

## Verification
Four properties are checked on every cycle: the length of every busy window measured against the timing fields captured at its start, the refusal of program requests with a wrong key or a locked bank, the error response to requests made while busy, and the stickiness of the error flag together with the key clearing after a burn. Only the bench scenarios can show what each operation does to the array contents. These cover the OR accumulation across repeated burns, isolation between neighbouring words, sense data after a refused or overlapped request, and the field masking of the control aliases and the timing register.

// File: rtl/fusebox_pkg.sv
package fusebox_pkg;

    localparam int REG_AW = 3;
    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

    localparam int KEY_LSB  = 16;
    localparam int ERR_BIT  = 9;
    localparam int BUSY_BIT = 8;

    localparam int RD_W  = 6;
    localparam int RLX_W = 4;
    localparam int PRG_W = 12;
    localparam int TIM_W = RD_W + RLX_W + PRG_W;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL       = 3'd0,
        REG_CTRL_SET   = 3'd1,
        REG_CTRL_CLR   = 3'd2,
        REG_TIMING     = 3'd3,
        REG_SENSE_GO   = 3'd4,
        REG_PROG_DATA  = 3'd5,
        REG_SENSE_DATA = 3'd6,
        REG_BANK_LOCK  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RELAX,
        PH_STROBE
    } phase_e;

    typedef enum logic {
        OP_SENSE,
        OP_PROG
    } op_e;

    // Packed so that the struct matches bits 21:0 of the timing register.
    typedef struct packed {
        logic [RD_W-1:0]  rd;
        logic [RLX_W-1:0] relax;
        logic [PRG_W-1:0] prog;
    } timing_t;

    localparam timing_t TIMING_RST = '{rd: 6'd6, relax: 4'd1, prog: 12'd20};

    function automatic logic [31:0] ctrl_word(logic [15:0] key, logic err,
                                              logic busy, logic [7:0] addr);
        return {key, 6'd0, err, busy, addr};
    endfunction

    function automatic logic [31:0] timing_word(timing_t t);
        return {{(32-TIM_W){1'b0}}, t};
    endfunction

endpackage

// File: rtl/fusebox_array.sv
module fusebox_array #(
    parameter int NWORDS = 128,
    parameter int AW     = 7,
    parameter int DW     = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [NWORDS];

    // Behavioural fuses: a burn can only set bits.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) begin
                mem[i] <= '0;
            end
        end else if (we) begin
            mem[addr] <= mem[addr] | wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/fusebox_seq.sv
module fusebox_seq
    import fusebox_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int WSEL  = 3,
    parameter int AW    = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_go,
    input  logic             prog_go,
    input  logic [31:0]      prog_data,
    input  logic [15:0]      key,
    input  logic [AW-1:0]    ctrl_addr,
    input  logic [BANKS-1:0] lock,
    input  timing_t          timing,
    output logic             busy,
    output logic             err_set,
    output logic             key_clr,
    output logic             sense_load,
    output logic             arr_we,
    output logic [AW-1:0]    arr_addr,
    output logic [31:0]      arr_wdata
);

    typedef struct packed {
        op_e              op;
        logic [AW-1:0]    addr;
        logic [31:0]      data;
        logic [PRG_W-1:0] strobe;
    } job_t;

    phase_e           phase;
    logic [PRG_W-1:0] cnt;
    job_t             job;

    logic key_ok;
    logic bank_locked;
    logic start;
    logic done;

    assign busy        = (phase != PH_IDLE);
    assign key_ok      = (key == UNLOCK_KEY);
    assign bank_locked = lock[ctrl_addr[AW-1:WSEL]];

    always_comb begin
        start   = 1'b0;
        err_set = 1'b0;
        if (sense_go || prog_go) begin
            if (busy) begin
                err_set = 1'b1;
            end else if (prog_go && (!key_ok || bank_locked)) begin
                err_set = 1'b1;
            end else begin
                start = 1'b1;
            end
        end
    end

    assign done = (phase == PH_STROBE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            job   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase      <= PH_RELAX;
                        cnt        <= PRG_W'(timing.relax);
                        job.op     <= prog_go ? OP_PROG : OP_SENSE;
                        job.addr   <= ctrl_addr;
                        job.data   <= prog_data;
                        job.strobe <= prog_go ? timing.prog : PRG_W'(timing.rd);
                    end
                end
                PH_RELAX: begin
                    if (cnt == '0) begin
                        phase <= PH_STROBE;
                        cnt   <= job.strobe;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (cnt == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign arr_we     = done && (job.op == OP_PROG);
    assign sense_load = done && (job.op == OP_SENSE);
    assign key_clr    = arr_we;
    assign arr_addr   = job.addr;
    assign arr_wdata  = job.data;

endmodule

// File: rtl/fusebox_regs.sv
module fusebox_regs
    import fusebox_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int AW    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              err_set,
    input  logic              key_clr,
    input  logic              sense_load,
    input  logic [31:0]       sense_word,
    output logic [15:0]       key,
    output logic [AW-1:0]     ctrl_addr,
    output logic              err,
    output timing_t           timing,
    output logic [BANKS-1:0]  lock,
    output logic              sense_go,
    output logic              prog_go,
    output logic [31:0]       prog_data
);

    reg_sel_e    sel;
    logic [31:0] sense_data;
    logic [15:0] wkey;
    logic [AW-1:0] waddr;

    assign sel   = reg_sel_e'(bus_addr);
    assign wkey  = bus_wdata[KEY_LSB +: 16];
    assign waddr = bus_wdata[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            key        <= '0;
            ctrl_addr  <= '0;
            err        <= 1'b0;
            timing     <= TIMING_RST;
            lock       <= '0;
            sense_data <= '0;
        end else begin
            if (bus_wr) begin
                case (sel)
                    REG_CTRL: begin
                        key       <= wkey;
                        ctrl_addr <= waddr;
                    end
                    REG_CTRL_SET: begin
                        key       <= key | wkey;
                        ctrl_addr <= ctrl_addr | waddr;
                    end
                    REG_CTRL_CLR: begin
                        key       <= key & ~wkey;
                        ctrl_addr <= ctrl_addr & ~waddr;
                        if (bus_wdata[ERR_BIT]) begin
                            err <= 1'b0;
                        end
                    end
                    REG_TIMING:    timing <= timing_t'(bus_wdata[TIM_W-1:0]);
                    REG_BANK_LOCK: lock   <= bus_wdata[BANKS-1:0];
                    default: ;
                endcase
            end
            if (err_set) begin
                err <= 1'b1;
            end
            // A finished burn consumes the key, even over a same-cycle write.
            if (key_clr) begin
                key <= '0;
            end
            if (sense_load) begin
                sense_data <= sense_word;
            end
        end
    end

    assign sense_go  = bus_wr && (sel == REG_SENSE_GO) && bus_wdata[0];
    assign prog_go   = bus_wr && (sel == REG_PROG_DATA);
    assign prog_data = bus_wdata;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                REG_CTRL, REG_CTRL_SET, REG_CTRL_CLR:
                    bus_rdata = ctrl_word(key, err, busy, 8'(ctrl_addr));
                REG_TIMING:     bus_rdata = timing_word(timing);
                REG_SENSE_DATA: bus_rdata = sense_data;
                REG_BANK_LOCK:  bus_rdata = 32'(lock);
                default:        bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fusebox_ctrl.sv
module fusebox_ctrl
    import fusebox_pkg::*;
#(
    parameter int BANKS          = 16,
    parameter int WORDS_PER_BANK = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int WSEL   = $clog2(WORDS_PER_BANK);
    localparam int BSEL   = $clog2(BANKS);
    localparam int AW     = WSEL + BSEL;
    localparam int NWORDS = BANKS * WORDS_PER_BANK;

    logic             busy;
    logic             err;
    logic             err_set;
    logic             key_clr;
    logic             sense_load;
    logic             sense_go;
    logic             prog_go;
    logic             arr_we;
    logic [15:0]      key;
    logic [AW-1:0]    ctrl_addr;
    logic [AW-1:0]    arr_addr;
    logic [BANKS-1:0] lock;
    timing_t          timing;
    logic [31:0]      prog_data;
    logic [31:0]      arr_wdata;
    logic [31:0]      arr_rdata;

    fusebox_regs #(
        .BANKS (BANKS),
        .AW    (AW)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (busy),
        .err_set    (err_set),
        .key_clr    (key_clr),
        .sense_load (sense_load),
        .sense_word (arr_rdata),
        .key        (key),
        .ctrl_addr  (ctrl_addr),
        .err        (err),
        .timing     (timing),
        .lock       (lock),
        .sense_go   (sense_go),
        .prog_go    (prog_go),
        .prog_data  (prog_data)
    );

    fusebox_seq #(
        .BANKS (BANKS),
        .WSEL  (WSEL),
        .AW    (AW)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sense_go   (sense_go),
        .prog_go    (prog_go),
        .prog_data  (prog_data),
        .key        (key),
        .ctrl_addr  (ctrl_addr),
        .lock       (lock),
        .timing     (timing),
        .busy       (busy),
        .err_set    (err_set),
        .key_clr    (key_clr),
        .sense_load (sense_load),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_wdata  (arr_wdata)
    );

    fusebox_array #(
        .NWORDS (NWORDS),
        .AW     (AW),
        .DW     (32)
    ) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (arr_we),
        .addr  (arr_addr),
        .wdata (arr_wdata),
        .rdata (arr_rdata)
    );

endmodule

// File: rtl/fusebox_chk.sv
module fusebox_chk
    import fusebox_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int WSEL  = 3,
    parameter int AW    = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              err,
    input logic [15:0]       key,
    input logic [BANKS-1:0]  lock,
    input logic [AW-1:0]     ctrl_addr,
    input timing_t           timing,
    input logic              arr_we
);

    logic        prog_req;
    logic        sense_req;
    logic [15:0] run_len;
    logic [15:0] want_len;

    assign prog_req  = bus_wr && (bus_addr == REG_PROG_DATA);
    assign sense_req = bus_wr && (bus_addr == REG_SENSE_GO) && bus_wdata[0];

    // Window counter: length of each busy run against the timing captured at its start.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len  <= '0;
            want_len <= '0;
        end else begin
            run_len <= busy ? run_len + 16'd1 : 16'd0;
            if (!busy && prog_req) begin
                want_len <= 16'(timing.relax) + 16'(timing.prog) + 16'd2;
            end else if (!busy && sense_req) begin
                want_len <= 16'(timing.relax) + 16'(timing.rd) + 16'd2;
            end
        end
    end

    assert_busy_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_len == want_len));

    assert_key_spent_R4: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> (key == 16'd0));

    assert_bad_key_R5: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !busy && (key != UNLOCK_KEY)) |=> (err && !busy));

    assert_locked_bank_R6: assert property (@(posedge clk) disable iff (rst)
        (prog_req && !busy && (key == UNLOCK_KEY) && lock[ctrl_addr[AW-1:WSEL]])
        |=> (err && !busy));

    assert_busy_reject_R7: assert property (@(posedge clk) disable iff (rst)
        ((prog_req || sense_req) && busy) |=> err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (err && !(bus_wr && (bus_addr == REG_CTRL_CLR) && bus_wdata[ERR_BIT])) |=> err);

endmodule

bind fusebox_ctrl fusebox_chk #(
    .BANKS (BANKS),
    .WSEL  (WSEL),
    .AW    (AW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .err       (err),
    .key       (key),
    .lock      (lock),
    .ctrl_addr (ctrl_addr),
    .timing    (timing),
    .arr_we    (arr_we)
);

// File: tb/fusebox_ctrl_bench.sv
`timescale 1ns/1ps
module fusebox_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic        bus_rd;
    logic [2:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    always #10 clk = ~clk;

    fusebox_ctrl u_fusebox_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    string       cur_req = "R1";
    logic [31:0] last_rd;
    bit          done = 1'b0;

    // Behavioural reference state
    logic [31:0] m_fuse [0:127];
    logic [15:0] m_key;
    logic        m_err;
    logic [6:0]  m_addr;
    int          m_rd, m_rlx, m_prg;
    logic [31:0] m_sense;
    logic [15:0] m_lock;
    int          m_left;
    int          m_op;
    logic [6:0]  m_oaddr;
    logic [31:0] m_odata;

    task automatic m_init();
        for (int i = 0; i < 128; i++) m_fuse[i] = '0;
        m_key = '0; m_err = 1'b0; m_addr = '0;
        m_rd = 6; m_rlx = 1; m_prg = 20;
        m_sense = '0; m_lock = '0; m_left = 0; m_op = 0;
        m_oaddr = '0; m_odata = '0;
    endtask

    function automatic logic [31:0] m_read(int a);
        case (a)
            0, 1, 2: return {m_key, 6'd0, m_err, (m_left > 0), 1'b0, m_addr};
            3:       return (m_rd << 16) | (m_rlx << 12) | m_prg;
            6:       return m_sense;
            7:       return {16'd0, m_lock};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_step(bit wr, int a, logic [31:0] d);
        bit was_busy;
        was_busy = (m_left > 0);
        if (wr) begin
            case (a)
                0: begin m_key = d[31:16]; m_addr = d[6:0]; end
                1: begin m_key = m_key | d[31:16]; m_addr = m_addr | d[6:0]; end
                2: begin
                    m_key  = m_key & ~d[31:16];
                    m_addr = m_addr & ~d[6:0];
                    if (d[9]) m_err = 1'b0;
                end
                3: begin m_rd = int'(d[21:16]); m_rlx = int'(d[15:12]); m_prg = int'(d[11:0]); end
                4: if (d[0]) begin
                    if (was_busy) m_err = 1'b1;
                    else begin m_op = 1; m_oaddr = m_addr; m_left = m_rlx + m_rd + 2; end
                end
                5: begin
                    if (was_busy || m_key != 16'h3E77 || m_lock[m_addr[6:3]]) m_err = 1'b1;
                    else begin m_op = 2; m_oaddr = m_addr; m_odata = d; m_left = m_rlx + m_prg + 2; end
                end
                7: m_lock = d[15:0];
                default: ;
            endcase
        end
        if (was_busy) begin
            m_left = m_left - 1;
            if (m_left == 0) begin
                if (m_op == 1) m_sense = m_fuse[m_oaddr];
                else begin
                    m_fuse[m_oaddr] = m_fuse[m_oaddr] | m_odata;
                    m_key = '0;
                end
            end
        end
    endtask

    // One bus cycle; read data of the same offset is compared against the model.
    task automatic cyc(bit wr, int a, logic [31:0] d);
        logic [31:0] exp;
        @(negedge clk);
        bus_wr = wr; bus_addr = a[2:0]; bus_wdata = d; bus_rd = 1'b1;
        #1;
        last_rd = bus_rdata;
        exp = m_read(a);
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s model offset %0d: actual %h expected %h", cur_req, a, bus_rdata, exp);
        end
        @(posedge clk);
        m_step(wr, a, d);
    endtask

    task automatic lit(logic [31:0] exp);
        n_cmp++;
        if (last_rd !== exp) begin
            n_bad++;
            $display("FAIL %s literal: actual %h expected %h", cur_req, last_rd, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 32'd0);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            report();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        m_init();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        cur_req = "R1";
        cyc(0, 0, 0); lit(32'h0);
        cyc(0, 3, 0); lit(32'h00061014);
        cyc(0, 6, 0); lit(32'h0);
        cyc(0, 7, 0); lit(32'h0);

        cur_req = "R9";
        cyc(1, 3, 32'hFFFF_FFFF); cyc(0, 3, 0); lit(32'h003F_FFFF);
        cyc(1, 3, 32'h0002_1005); cyc(0, 3, 0); lit(32'h0002_1005);

        cur_req = "R2";
        cyc(1, 0, 32'hABCD_03FF); cyc(0, 0, 0); lit(32'hABCD_007F);
        cyc(1, 2, 32'hFFFF_0070); cyc(0, 1, 0); lit(32'h0000_000F);
        cyc(1, 1, 32'h3E77_0010); cyc(0, 2, 0); lit(32'h3E77_001F);
        cyc(1, 2, 32'hFFFF_007F); cyc(0, 0, 0); lit(32'h0);

        cur_req = "R3";
        cyc(1, 0, 32'h5); cyc(1, 4, 32'h1);
        cyc(0, 0, 0); lit(32'h0000_0105);
        idle(10);
        cyc(0, 6, 0); lit(32'h0);
        cyc(1, 4, 32'hFFFF_FFFE); cyc(0, 0, 0); lit(32'h0000_0005);

        cur_req = "R4";
        cyc(1, 0, 32'h3E77_0013); cyc(1, 5, 32'h0000_00F0);
        cyc(0, 0, 0); lit(32'h3E77_0113);
        idle(10);
        cyc(0, 0, 0); lit(32'h0000_0013);
        cyc(1, 0, 32'h3E77_0013); cyc(1, 5, 32'h0F00_0001); idle(10);
        cyc(1, 4, 32'h1); idle(8);
        cyc(0, 6, 0); lit(32'h0F00_00F1);

        cur_req = "R10";
        cyc(1, 0, 32'h12); cyc(1, 4, 32'h1); idle(8);
        cyc(0, 6, 0); lit(32'h0);

        cur_req = "R5";
        cyc(1, 0, 32'h1234_0013); cyc(1, 5, 32'hFFFF_FFFF);
        cyc(0, 0, 0); lit(32'h1234_0213);
        cyc(1, 4, 32'h1); idle(8);
        cyc(0, 6, 0); lit(32'h0F00_00F1);

        cur_req = "R8";
        cyc(1, 0, 32'h0000_0213); cyc(0, 0, 0); lit(32'h0000_0213);
        cyc(1, 2, 32'h0000_0100); cyc(0, 0, 0); lit(32'h0000_0213);
        cyc(1, 2, 32'h0000_0200); cyc(0, 0, 0); lit(32'h0000_0013);

        cur_req = "R6";
        cyc(1, 7, 32'h0000_0004); cyc(0, 7, 0); lit(32'h0000_0004);
        cyc(1, 0, 32'h3E77_0013); cyc(1, 5, 32'h1);
        cyc(0, 0, 0); lit(32'h3E77_0213);
        cyc(1, 2, 32'h200);
        cyc(1, 0, 32'h3E77_0018); cyc(1, 5, 32'h55); idle(10);
        cyc(1, 4, 32'h1); idle(8);
        cyc(0, 6, 0); lit(32'h0000_0055);

        cur_req = "R7";
        cyc(1, 0, 32'h3E77_0018); cyc(1, 5, 32'h0000_0A00);
        cyc(1, 4, 32'h1); cyc(1, 5, 32'hFFFF_0000);
        idle(10);
        cyc(0, 0, 0); lit(32'h0000_0218);
        cyc(1, 2, 32'h200); cyc(1, 4, 32'h1); idle(8);
        cyc(0, 6, 0); lit(32'h0000_0A55);

        done = 1'b1;
        report();
        $finish;
    end

endmodule